// File: doc/BRIEF.md
# Split 32-bit Count-Up Timer Pair

This block is a memory-mapped timer that holds two independent 32-bit count-up counters, a lower half and an upper half. Software selects the split operating mode and releases each half from reset in a global control register. It then gives each half a two-bit enable mode (off, single run or repeating) in a shared timer control register. Each half counts one step per clock and raises its own interrupt when its count reaches its period.

In repeating mode a half returns to zero after the match and keeps counting, so a period of P gives one interrupt every P+1 clocks. A period of all ones makes the half a free-running 32-bit counter that interrupts once on each wrap. In single-run mode the half stops with its count at the period and its enable field returns to off. Software can read both counters at any time and can rewrite a counter or a period while the half runs.

Top module: `dual_count_timer`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: Word addresses are 0 global control, 1 timer control, 2 lower count, 3 upper count, 4 lower period, 5 upper period. In global control, bit 0 releases the lower half, bit 1 releases the upper half, and bits [3:2] hold the timer mode. All other bits read 0. In timer control, bits [7:6] are the lower enable mode and bits [23:22] are the upper enable mode, with 0 off, 1 single run and 2 repeating. A written 3 is stored and read back as 0, and all other bits read 0.
- R3: A half counts up by one per clock when it is released, the timer mode is 1 (split), and its enable mode is 1 or 2.
- R4: In repeating mode, when the count equals the period the count goes to zero on the next clock. The interrupt is high for that one clock, so a period P gives count N mod (P+1) and floor(N/(P+1)) interrupts over N clocks.
- R5: In single-run mode, at the match the half raises one interrupt, its count stays at the period, and its enable field reads 0.
- R6: A half whose release bit is 0 reads a count of zero, does not count and raises no interrupt, whatever its enable mode. A count write to it has no effect.
- R7: With any timer mode other than 1, neither half counts or interrupts, and the counts keep their values.
- R8: The two halves run independently, each with its own period, mode and interrupt.
- R9: A counter or period write takes effect on the next clock, and a counter write overrides that clock's count step.
- R10: With period all ones in repeating mode the count wraps from all ones to zero and raises one interrupt.
- R11: Writing zero to timer control stops both halves, and their counts hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr while bus_sel is high, otherwise 0 |
| irq_lo | output | 1 | Lower half match interrupt pulse |
| irq_hi | output | 1 | Upper half match interrupt pulse |

## Verification
A wrong count or a wrong match decision shows on the next clock: the counter read back is off by one step, or the interrupt pulse comes a clock early or late. Over a long window that becomes a wrong interrupt total. A single-run half that fails to stop shows as an enable field still reading 1 and a count past its period one clock after the match. A mode or release gate that leaks shows as a count that moves, or an interrupt from a half that should be silent, within a clock of the write.

// File: rtl/dct_pkg.sv
package dct_pkg;
    typedef enum logic [1:0] {
        RUN_OFF  = 2'd0,
        RUN_ONCE = 2'd1,
        RUN_LOOP = 2'd2
    } run_mode_e;

    localparam logic [1:0] GMODE_SPLIT = 2'd1;

    localparam logic [2:0] A_GLOB   = 3'd0;
    localparam logic [2:0] A_CTRL   = 3'd1;
    localparam logic [2:0] A_CNT_LO = 3'd2;
    localparam logic [2:0] A_CNT_HI = 3'd3;
    localparam logic [2:0] A_PRD_LO = 3'd4;
    localparam logic [2:0] A_PRD_HI = 3'd5;

    localparam int EN_POS_LO = 6;
    localparam int EN_POS_HI = 22;
endpackage

// File: rtl/dct_glob.sv
module dct_glob
    import dct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [3:0] wdata_i,
    output logic [1:0] rel_o,
    output logic [1:0] gmode_o
);
    typedef struct packed {
        logic [1:0] rel;
        logic [1:0] gmode;
    } glob_t;

    glob_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            s_d.rel   = wdata_i[1:0];
            s_d.gmode = wdata_i[3:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rel_o   = s_q.rel;
    assign gmode_o = s_q.gmode;
endmodule

// File: rtl/dct_half.sv
module dct_half
    import dct_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rel_i,
    input  logic         split_i,
    input  logic         mode_we_i,
    input  logic [1:0]   mode_wdata_i,
    input  logic         cnt_we_i,
    input  logic         prd_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] prd_o,
    output logic [1:0]   mode_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] prd;
        logic [1:0]   mode;
        logic         irq;
    } half_t;

    half_t s_d, s_q;
    logic  run;
    logic  hit;

    assign run = rel_i && split_i &&
                 (s_q.mode == RUN_ONCE || s_q.mode == RUN_LOOP);
    assign hit = (s_q.cnt == s_q.prd);

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (mode_we_i)
            s_d.mode = (mode_wdata_i == 2'b11) ? RUN_OFF : mode_wdata_i;
        if (prd_we_i)
            s_d.prd = wdata_i;
        if (!rel_i) begin
            s_d.cnt = '0;
        end else if (cnt_we_i) begin
            s_d.cnt = wdata_i;
        end else if (run) begin
            if (hit) begin
                s_d.irq = 1'b1;
                if (s_q.mode == RUN_ONCE) begin
                    if (!mode_we_i) s_d.mode = RUN_OFF;
                end else begin
                    s_d.cnt = '0;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o  = s_q.cnt;
    assign prd_o  = s_q.prd;
    assign mode_o = s_q.mode;
    assign irq_o  = s_q.irq;

    assert_held_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_i |=> (cnt_o == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_we_i && !hit) |=> (cnt_o == $past(cnt_o) + 1'b1));

    assert_loop_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_we_i && hit && s_q.mode == RUN_LOOP) |=> (cnt_o == '0 && irq_o));

    assert_once_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_we_i && !mode_we_i && hit && s_q.mode == RUN_ONCE)
        |=> (mode_o == RUN_OFF && $stable(cnt_o) && irq_o));

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(rel_i && split_i));
endmodule

// File: rtl/dual_count_timer.sv
module dual_count_timer
    import dct_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int NHALF = 2;

    logic             wr;
    logic [1:0]       rel;
    logic [1:0]       gmode;
    logic             split;
    logic [W-1:0]     cnt   [NHALF];
    logic [W-1:0]     prd   [NHALF];
    logic [1:0]       mode  [NHALF];
    logic [NHALF-1:0] irq;
    logic [W-1:0]     ctrl_rd;

    assign wr    = bus_sel && bus_wr;
    assign split = (gmode == GMODE_SPLIT);

    dct_glob u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr && bus_addr == A_GLOB),
        .wdata_i (bus_wdata[3:0]),
        .rel_o   (rel),
        .gmode_o (gmode)
    );

    for (genvar i = 0; i < NHALF; i++) begin : g_half
        localparam int EP = (i == 0) ? EN_POS_LO : EN_POS_HI;
        localparam logic [ADDR_W-1:0] A_C = (i == 0) ? A_CNT_LO : A_CNT_HI;
        localparam logic [ADDR_W-1:0] A_P = (i == 0) ? A_PRD_LO : A_PRD_HI;
        dct_half #(.W(W)) u_half (
            .clk          (clk),
            .rst_n        (rst_n),
            .rel_i        (rel[i]),
            .split_i      (split),
            .mode_we_i    (wr && bus_addr == A_CTRL),
            .mode_wdata_i (bus_wdata[EP +: 2]),
            .cnt_we_i     (wr && bus_addr == A_C),
            .prd_we_i     (wr && bus_addr == A_P),
            .wdata_i      (bus_wdata),
            .cnt_o        (cnt[i]),
            .prd_o        (prd[i]),
            .mode_o       (mode[i]),
            .irq_o        (irq[i])
        );
    end

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[EN_POS_LO +: 2] = mode[0];
        ctrl_rd[EN_POS_HI +: 2] = mode[1];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                A_GLOB:   bus_rdata = {{(W-4){1'b0}}, gmode, rel};
                A_CTRL:   bus_rdata = ctrl_rd;
                A_CNT_LO: bus_rdata = cnt[0];
                A_CNT_HI: bus_rdata = cnt[1];
                A_PRD_LO: bus_rdata = prd[0];
                A_PRD_HI: bus_rdata = prd[1];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq_lo = irq[0];
    assign irq_hi = irq[1];

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !split |=> (irq == '0));

    assert_mode_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == A_CTRL |=> (mode[0] != 2'b11 && mode[1] != 2'b11));
endmodule

// File: tb/test_dual_count_timer.sv
module test_dual_count_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi;

    int total = 0;
    int bad = 0;
    int n_lo = 0;
    int n_hi = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_count_timer i_dual_count_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always @(negedge clk) begin
        if (irq_lo) n_lo++;
        if (irq_hi) n_hi++;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        #1;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic int unsigned exp_cnt(input int m, input int unsigned p, input int unsigned n);
        if (m == 2) return n % (p + 1);
        if (m == 1) return (n < p) ? n : p;
        return 0;
    endfunction

    function automatic int unsigned exp_irq(input int m, input int unsigned p, input int unsigned n);
        if (m == 2) return n / (p + 1);
        if (m == 1) return (n > p) ? 1 : 0;
        return 0;
    endfunction

    function automatic int exp_mode(input int m, input int unsigned p, input int unsigned n);
        if (m == 1 && n > p) return 0;
        return m;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int b0, b1;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));

        #35 rst_n = 1;
        @(negedge clk); #1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            peek(a[2:0], v);
            check("R1 reset register", v, 0);
        end
        check("R1 irq_lo reset", {31'b0, irq_lo}, 0);
        check("R1 irq_hi reset", {31'b0, irq_hi}, 0);

        // R2 layout
        wr(3'd0, 32'hFFFF_FFFF);
        peek(3'd0, v); check("R2 global readback", v, 32'hF);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'hFFFF_FFFF);
        peek(3'd1, v); check("R2 code 3 masked", v, 0);
        wr(3'd1, (32'd1 << 6) | (32'd2 << 22));
        peek(3'd1, v); check("R2 ctrl fields", v, (32'd1 << 6) | (32'd2 << 22));
        wr(3'd1, 32'h0);

        // R3 R4 R8 random rounds, both halves
        wr(3'd0, 32'h7);
        for (int r = 0; r < 10; r++) begin
            int m0, m1, n;
            int unsigned p0, p1;
            m0 = $urandom_range(2, 0); m1 = $urandom_range(2, 0);
            p0 = $urandom_range(40, 0); p1 = $urandom_range(40, 0);
            n  = $urandom_range(150, 1);
            if (r == 0) begin m0 = 2; p0 = 0; m1 = 1; p1 = 0; end
            if (r == 1) begin m0 = 1; p0 = 7; m1 = 2; p1 = 5; n = 30; end
            wr(3'd1, 32'h0);
            wr(3'd2, 32'h0); wr(3'd3, 32'h0);
            wr(3'd4, p0);    wr(3'd5, p1);
            wr(3'd1, (m0 << 6) | (m1 << 22));
            b0 = n_lo; b1 = n_hi;
            wait_n(n);
            peek(3'd2, v);  check("R3 R4 R5 lower count", v, exp_cnt(m0, p0, n));
            peek(3'd3, v);  check("R8 upper count", v, exp_cnt(m1, p1, n));
            check("R4 lower irq total", n_lo - b0, exp_irq(m0, p0, n));
            check("R8 upper irq total", n_hi - b1, exp_irq(m1, p1, n));
            peek(3'd1, v);
            check("R5 ctrl after run", v, (exp_mode(m0, p0, n) << 6) | (exp_mode(m1, p1, n) << 22));
        end

        // R5 directed single run: count holds after match
        wr(3'd1, 32'h0); wr(3'd2, 32'h0); wr(3'd4, 32'd3);
        wr(3'd1, 32'd1 << 6);
        b0 = n_lo;
        wait_n(3);
        peek(3'd1, v); check("R5 still armed before match", v, 32'd1 << 6);
        wait_n(1);
        peek(3'd1, v); check("R5 field cleared", v, 0);
        check("R5 one pulse", n_lo - b0, 1);
        wait_n(10);
        peek(3'd2, v); check("R5 count holds at period", v, 3);
        check("R5 no second pulse", n_lo - b0, 1);

        // R9 counter write overrides step
        wr(3'd4, 32'd200); wr(3'd2, 32'd0);
        wr(3'd1, 32'd2 << 6);
        wait_n(4);
        wr(3'd2, 32'd100);
        peek(3'd2, v); check("R9 count write wins", v, 100);
        wait_n(5);
        peek(3'd2, v); check("R9 count after write", v, 105);

        // R11 zero ctrl stops both
        wr(3'd1, 32'h0);
        peek(3'd2, v);
        wait_n(7);
        peek(3'd2, v2); check("R11 count holds", v2, v);

        // R10 full period wrap
        wr(3'd2, 32'hFFFF_FFFC); wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd1, 32'd2 << 6);
        b0 = n_lo;
        wait_n(3);
        peek(3'd2, v); check("R10 at all ones", v, 32'hFFFF_FFFF);
        wait_n(1);
        peek(3'd2, v); check("R10 wrapped to zero", v, 0);
        check("R10 wrap pulse", n_lo - b0, 1);
        wr(3'd1, 32'h0);

        // R6 lower held in reset
        wr(3'd0, 32'h6);
        wr(3'd2, 32'd9);
        peek(3'd2, v); check("R6 held count zero", v, 0);
        wr(3'd4, 32'd5); wr(3'd5, 32'd5); wr(3'd3, 32'd0);
        wr(3'd1, (32'd2 << 6) | (32'd2 << 22));
        b0 = n_lo; b1 = n_hi;
        wait_n(20);
        peek(3'd2, v); check("R6 held no count", v, 0);
        check("R6 held no irq", n_lo - b0, 0);
        peek(3'd3, v); check("R8 released upper counts", v, 20 % 6);
        check("R8 upper irqs", n_hi - b1, 3);

        // R7 non-split mode freezes both
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h3);
        wr(3'd2, 32'd9); wr(3'd3, 32'd11);
        wr(3'd4, 32'd2); wr(3'd5, 32'd2);
        wr(3'd1, (32'd2 << 6) | (32'd2 << 22));
        b0 = n_lo; b1 = n_hi;
        wait_n(25);
        peek(3'd2, v); check("R7 lower frozen", v, 9);
        peek(3'd3, v); check("R7 upper frozen", v, 11);
        check("R7 no irq", (n_lo - b0) + (n_hi - b1), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule